// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. It keeps the valid bit of each pipeline latch and the registered taken-branch flag. From the datapath it takes the instruction class and register fields held in those latches, the branch-condition result computed in execute, and an external flush request. Each cycle it decides whether to stall on a load-use dependency and whether to squash the younger instructions behind a taken branch. It also picks the source of the next program counter and steers the forwarding multiplexers for both execute operands.

Five instruction classes are recognised: register-register, register-immediate, load, store and branch. The ALU, register file, memories and the datapath latch contents sit outside the block. The datapath reads this block's selects and strobes and updates its own latches.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four stage valid bits and the taken-branch flag, so squash is low after reset.
- R2: The class field is 3 bits wide, coded as RR=0, RI=1, LD=2, ST=3 and BR=4. Any other code behaves exactly like RI.
- R3: stall is high when all of the following hold: decode/execute is valid with class LD, fetch/decode is valid, and the load destination equals the fetch/decode first source. It is also high under the same conditions when the load destination equals the fetch/decode second source and the fetch/decode class is RR, ST or BR.
- R4: During a stall, decode/execute is invalid in the next cycle and fetch/decode keeps its valid bit.
- R5: The taken-branch flag is set at the next edge when squash is low, decode/execute is valid, its class is BR and brTrue is high. squash is the output of this flag.
- R6: While squash is high, fetch/decode, decode/execute and execute/memory are all invalid in the next cycle.
- R7: For each execute operand, the select is 1 (execute/memory result) when execute/memory is valid, its class is RR or RI, and its destination equals that operand's source. Otherwise it is 2 (writeback data) when writeback is valid and its destination matches. Otherwise it is 0 (decode value).
- R8: aluBImm is high when the decode/execute class is RI, LD or ST, and low for RR and BR.
- R9: pcSel is 2 (branch target) when squash is high. Otherwise it is 1 (hold) when stall or flushReq is high. Otherwise it is 0 (increment).
- R10: Next fetch/decode valid = (stall OR NOT flushReq) AND NOT squash, so a flush takes effect only once a stall has cleared.
- R11: Writeback becomes valid when execute/memory is valid with class RR, RI or LD. memWrite is high only when execute/memory is valid with class ST.
- R12: Register 0 takes part in matching like every other register identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flushReq | input | 1 | External request to drain the front end |
| fdClass | input | 3 | Class code in the fetch/decode latch |
| fdSrcA | input | REG_W | First source register in fetch/decode |
| fdSrcB | input | REG_W | Second source register in fetch/decode |
| deClass | input | 3 | Class code in the decode/execute latch |
| deDest | input | REG_W | Destination register in decode/execute |
| deSrcA | input | REG_W | First source register in decode/execute |
| deSrcB | input | REG_W | Second source register in decode/execute |
| brTrue | input | 1 | Branch condition evaluated on the forwarded operands |
| emClass | input | 3 | Class code in the execute/memory latch |
| emDest | input | REG_W | Destination register in execute/memory |
| mwDest | input | REG_W | Destination register in memory/writeback |
| stall | output | 1 | Load-use stall |
| squash | output | 1 | Kill the younger instructions after a taken branch |
| fdValid | output | 1 | Fetch/decode valid bit |
| deValid | output | 1 | Decode/execute valid bit |
| emValid | output | 1 | Execute/memory valid bit |
| mwValid | output | 1 | Writeback valid bit (register-file write enable) |
| pcSel | output | 2 | 0 increment, 1 hold, 2 branch target |
| fwdASel | output | 2 | First operand source: 0 decode, 1 execute/memory, 2 writeback |
| fwdBSel | output | 2 | Second operand source, same coding |
| aluBImm | output | 1 | Second ALU input takes the immediate |
| memWrite | output | 1 | Store commits to data memory |

## Verification
The bench builds the block with the default 5-bit register identifiers. That width is wide enough to set up matching and non-matching fields in every latch at once, and it includes register 0 for the no-hard-wired-zero case. The bench fills the pipeline by running clean cycles and then drives the latch fields directly. This brings the interactions between signals within reach: a stall overlapping a flush, both later stages matching the same source, a branch already sitting behind a squash, and undefined class codes in each latch.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_RR = 3'd0,
    CLS_RI = 3'd1,
    CLS_LD = 3'd2,
    CLS_ST = 3'd3,
    CLS_BR = 3'd4
  } instClass_e;

  typedef enum logic [1:0] {
    FWD_DECODE = 2'd0,
    FWD_EXMEM  = 2'd1,
    FWD_MEMWB  = 2'd2
  } fwdSel_e;

  typedef enum logic [1:0] {
    PC_INC    = 2'd0,
    PC_HOLD   = 2'd1,
    PC_TARGET = 2'd2
  } pcSel_e;

  // strobes from the hazard decision logic to the valid-bit state
  typedef struct packed {
    logic stall;
    logic squash;
    logic fdNext;
    logic deNext;
    logic emNext;
    logic mwNext;
    logic takenNext;
  } ctrlStrobes_t;

  // undefined codes fold onto register-immediate
  function automatic instClass_e decodeClass(logic [CLASS_W-1:0] code);
    instClass_e cls;
    case (code)
      3'd0:    cls = CLS_RR;
      3'd2:    cls = CLS_LD;
      3'd3:    cls = CLS_ST;
      3'd4:    cls = CLS_BR;
      default: cls = CLS_RI;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/hzd_decide.sv
module hzd_decide
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flushReq,
  input  logic [CLASS_W-1:0] fdClass,
  input  logic [REG_W-1:0]   fdSrcA,
  input  logic [REG_W-1:0]   fdSrcB,
  input  logic [CLASS_W-1:0] deClass,
  input  logic [REG_W-1:0]   deDest,
  input  logic [REG_W-1:0]   deSrcA,
  input  logic [REG_W-1:0]   deSrcB,
  input  logic               brTrue,
  input  logic [CLASS_W-1:0] emClass,
  input  logic [REG_W-1:0]   emDest,
  input  logic [REG_W-1:0]   mwDest,
  input  logic               fdValid,
  input  logic               deValid,
  input  logic               emValid,
  input  logic               mwValid,
  input  logic               takenQ,
  output ctrlStrobes_t       strobes,
  output pcSel_e             pcSel,
  output fwdSel_e            fwdASel,
  output fwdSel_e            fwdBSel,
  output logic               aluBImm,
  output logic               memWrite
);

  localparam int NUM_OPS = 2;

  instClass_e fdCls, deCls, emCls;
  logic       fdReadsB;
  logic       loadUse;
  logic       squashNow;
  logic       emFwdOk;
  logic [REG_W-1:0] opSrc [NUM_OPS];
  fwdSel_e          opSel [NUM_OPS];

  assign fdCls = decodeClass(fdClass);
  assign deCls = decodeClass(deClass);
  assign emCls = decodeClass(emClass);

  // second source only counts for classes that really read it
  assign fdReadsB = (fdCls == CLS_RR) || (fdCls == CLS_ST) || (fdCls == CLS_BR);

  assign loadUse = deValid && (deCls == CLS_LD) && fdValid &&
                   ((deDest == fdSrcA) || (fdReadsB && (deDest == fdSrcB)));

  assign squashNow = takenQ;

  // a load result is not ready in execute/memory, so it never forwards from there
  assign emFwdOk = emValid && ((emCls == CLS_RR) || (emCls == CLS_RI));

  assign opSrc[0] = deSrcA;
  assign opSrc[1] = deSrcB;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_fwd
    assign opSel[k] = (emFwdOk && (emDest == opSrc[k])) ? FWD_EXMEM :
                      (mwValid && (mwDest == opSrc[k])) ? FWD_MEMWB :
                                                          FWD_DECODE;
  end

  assign fwdASel = opSel[0];
  assign fwdBSel = opSel[1];

  assign aluBImm  = (deCls == CLS_RI) || (deCls == CLS_LD) || (deCls == CLS_ST);
  assign memWrite = emValid && (emCls == CLS_ST);

  always_comb begin
    if (squashNow)                pcSel = PC_TARGET;
    else if (loadUse || flushReq) pcSel = PC_HOLD;
    else                          pcSel = PC_INC;
  end

  always_comb begin
    strobes.stall     = loadUse;
    strobes.squash    = squashNow;
    strobes.fdNext    = (loadUse || !flushReq) && !squashNow;
    strobes.deNext    = !squashNow && !loadUse && fdValid;
    strobes.emNext    = !squashNow && deValid;
    strobes.mwNext    = emValid && ((emCls == CLS_RR) || (emCls == CLS_RI) ||
                                    (emCls == CLS_LD));
    strobes.takenNext = !squashNow && deValid && (deCls == CLS_BR) && brTrue;
  end

  // R7: an execute/memory forward needs a live producer in that stage
  assert_fwd_live_R7: assert property (@(posedge clk) disable iff (rst)
    (fwdASel == FWD_EXMEM) |-> emValid);

  // R7: a writeback forward needs a valid writeback
  assert_fwdb_live_R7: assert property (@(posedge clk) disable iff (rst)
    (fwdBSel == FWD_MEMWB) |-> mwValid);

  // R3: a stall can only come from a valid load in decode/execute
  assert_stall_load_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.stall |-> (deValid && fdValid));

  // R9: a taken branch overrides holding the program counter
  assert_pc_branch_R9: assert property (@(posedge clk) disable iff (rst)
    takenQ |-> (pcSel == PC_TARGET));

endmodule

// File: rtl/hzd_state.sv
module hzd_state
  import hzd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  output logic         fdValid,
  output logic         deValid,
  output logic         emValid,
  output logic         mwValid,
  output logic         takenQ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fdValid <= 1'b0;
      deValid <= 1'b0;
      emValid <= 1'b0;
      mwValid <= 1'b0;
      takenQ  <= 1'b0;
    end else begin
      fdValid <= strobes.fdNext;
      deValid <= strobes.deNext;
      emValid <= strobes.emNext;
      mwValid <= strobes.mwNext;
      takenQ  <= strobes.takenNext;
    end
  end

  // R4: a stall leaves a bubble in decode/execute
  assert_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.stall |=> !deValid);

  // R10: a stall without squash keeps fetch/decode alive even under flush
  assert_hold_fd_R10: assert property (@(posedge clk) disable iff (rst)
    (strobes.stall && !strobes.squash) |=> fdValid);

  // R6: squash empties the three younger stages and cannot repeat at once
  assert_squash_clear_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.squash |=> (!fdValid && !deValid && !emValid && !takenQ));

  // R11: writeback only follows a valid execute/memory stage
  assert_wb_origin_R11: assert property (@(posedge clk) disable iff (rst)
    mwValid |-> $past(emValid));

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flushReq,
  input  logic [2:0]       fdClass,
  input  logic [REG_W-1:0] fdSrcA,
  input  logic [REG_W-1:0] fdSrcB,
  input  logic [2:0]       deClass,
  input  logic [REG_W-1:0] deDest,
  input  logic [REG_W-1:0] deSrcA,
  input  logic [REG_W-1:0] deSrcB,
  input  logic             brTrue,
  input  logic [2:0]       emClass,
  input  logic [REG_W-1:0] emDest,
  input  logic [REG_W-1:0] mwDest,
  output logic             stall,
  output logic             squash,
  output logic             fdValid,
  output logic             deValid,
  output logic             emValid,
  output logic             mwValid,
  output logic [1:0]       pcSel,
  output logic [1:0]       fwdASel,
  output logic [1:0]       fwdBSel,
  output logic             aluBImm,
  output logic             memWrite
);

  ctrlStrobes_t strobes;
  pcSel_e       pcSelE;
  fwdSel_e      fwdAE, fwdBE;
  logic         takenQ;

  hzd_decide #(.REG_W(REG_W)) u_decide (
    .clk      (clk),
    .rst      (rst),
    .flushReq (flushReq),
    .fdClass  (fdClass),
    .fdSrcA   (fdSrcA),
    .fdSrcB   (fdSrcB),
    .deClass  (deClass),
    .deDest   (deDest),
    .deSrcA   (deSrcA),
    .deSrcB   (deSrcB),
    .brTrue   (brTrue),
    .emClass  (emClass),
    .emDest   (emDest),
    .mwDest   (mwDest),
    .fdValid  (fdValid),
    .deValid  (deValid),
    .emValid  (emValid),
    .mwValid  (mwValid),
    .takenQ   (takenQ),
    .strobes  (strobes),
    .pcSel    (pcSelE),
    .fwdASel  (fwdAE),
    .fwdBSel  (fwdBE),
    .aluBImm  (aluBImm),
    .memWrite (memWrite)
  );

  hzd_state u_state (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .fdValid (fdValid),
    .deValid (deValid),
    .emValid (emValid),
    .mwValid (mwValid),
    .takenQ  (takenQ)
  );

  assign stall   = strobes.stall;
  assign squash  = strobes.squash;
  assign pcSel   = pcSelE;
  assign fwdASel = fwdAE;
  assign fwdBSel = fwdBE;

endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flushReq = 1'b0;
  logic [2:0] fdClass = 3'd0, deClass = 3'd0, emClass = 3'd0;
  logic [REG_W-1:0] fdSrcA = '0, fdSrcB = '0, deDest = '0, deSrcA = '0, deSrcB = '0;
  logic [REG_W-1:0] emDest = '0, mwDest = '0;
  logic brTrue = 1'b0;
  logic stall, squash, fdValid, deValid, emValid, mwValid, aluBImm, memWrite;
  logic [1:0] pcSel, fwdASel, fwdBSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(REG_W)) u_pipe_hazard_ctrl (
    .clk(clk), .rst(rst), .flushReq(flushReq),
    .fdClass(fdClass), .fdSrcA(fdSrcA), .fdSrcB(fdSrcB),
    .deClass(deClass), .deDest(deDest), .deSrcA(deSrcA), .deSrcB(deSrcB),
    .brTrue(brTrue), .emClass(emClass), .emDest(emDest), .mwDest(mwDest),
    .stall(stall), .squash(squash), .fdValid(fdValid), .deValid(deValid),
    .emValid(emValid), .mwValid(mwValid), .pcSel(pcSel),
    .fwdASel(fwdASel), .fwdBSel(fwdBSel), .aluBImm(aluBImm), .memWrite(memWrite)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // fill the pipeline with independent register-register work
  task automatic settle();
    @(negedge clk);
    rst = 1'b1; flushReq = 1'b0; brTrue = 1'b0;
    fdClass = 3'd0; fdSrcA = 5'd1;  fdSrcB = 5'd2;
    deClass = 3'd0; deDest = 5'd10; deSrcA = 5'd11; deSrcB = 5'd12;
    emClass = 3'd0; emDest = 5'd20; mwDest = 5'd21;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 fdValid", fdValid, 0); check("R1 deValid", deValid, 0);
    check("R1 emValid", emValid, 0); check("R1 mwValid", mwValid, 0);
    check("R1 squash", squash, 0);
    settle();
    check("R10 fill fdValid", fdValid, 1); check("R9 pc increment", pcSel, 0);
    check("R11 fill mwValid", mwValid, 1);
  endtask

  task automatic testLoadUse();
    settle();
    deClass = 3'd2; deDest = 5'd1;           // load writes first source of fd
    #1;
    check("R3 load-use on A", stall, 1); check("R9 hold on stall", pcSel, 1);
    @(negedge clk);
    check("R4 bubble deValid", deValid, 0); check("R4 fd held", fdValid, 1);
    check("R3 stall drops with bubble", stall, 0);
    settle();
    deClass = 3'd2; deDest = 5'd2; fdClass = 3'd0; #1;
    check("R3 RR second source", stall, 1);
    fdClass = 3'd1; #1;
    check("R3 RI second source ignored", stall, 0);
    fdClass = 3'd6; #1;
    check("R2 undefined code as RI", stall, 0);
    fdClass = 3'd3; #1;
    check("R3 ST second source", stall, 1);
    fdClass = 3'd4; #1;
    check("R3 BR second source", stall, 1);
    deClass = 3'd0; #1;
    check("R3 non-load no stall", stall, 0);
    deClass = 3'd2; deDest = 5'd0; fdSrcA = 5'd0; fdClass = 3'd1; #1;
    check("R12 register zero matches", stall, 1);
  endtask

  task automatic testForward();
    settle();
    deSrcA = 5'd3; deSrcB = 5'd3; emDest = 5'd3; mwDest = 5'd3; #1;
    check("R7 exmem wins A", fwdASel, 1); check("R7 exmem wins B", fwdBSel, 1);
    emClass = 3'd2; #1;
    check("R7 load not from exmem", fwdASel, 2);
    emClass = 3'd3; #1;
    check("R7 store not from exmem", fwdBSel, 2);
    emClass = 3'd5; #1;
    check("R2 undefined em code forwards as RI", fwdASel, 1);
    emClass = 3'd2; mwDest = 5'd4; #1;
    check("R7 decode value", fwdASel, 0);
    deSrcB = 5'd4; #1;
    check("R7 writeback on B", fwdBSel, 2);
    emClass = 3'd1; emDest = 5'd0; deSrcA = 5'd0; #1;
    check("R12 zero forwards", fwdASel, 1);
    deClass = 3'd1; #1; check("R8 RI immediate", aluBImm, 1);
    deClass = 3'd2; #1; check("R8 LD immediate", aluBImm, 1);
    deClass = 3'd3; #1; check("R8 ST immediate", aluBImm, 1);
    deClass = 3'd0; #1; check("R8 RR register", aluBImm, 0);
    deClass = 3'd4; #1; check("R8 BR register", aluBImm, 0);
    deClass = 3'd7; #1; check("R2 undefined de code immediate", aluBImm, 1);
  endtask

  task automatic testFlush();
    settle();
    deClass = 3'd2; deDest = 5'd1; flushReq = 1'b1; #1;
    check("R9 hold", pcSel, 1);
    @(negedge clk);
    check("R10 flush deferred by stall", fdValid, 1);
    check("R4 bubble under flush", deValid, 0);
    check("R9 hold on flush", pcSel, 1);
    @(negedge clk);
    check("R10 flush applied", fdValid, 0);
    flushReq = 1'b0;
    @(negedge clk);
    check("R10 refill", fdValid, 1);
  endtask

  task automatic testBranch();
    settle();
    deClass = 3'd4; brTrue = 1'b1; #1;
    check("R5 no squash yet", squash, 0);
    @(negedge clk);
    check("R5 squash after taken", squash, 1);
    check("R9 branch target", pcSel, 2);
    @(negedge clk);
    check("R6 fd cleared", fdValid, 0); check("R6 de cleared", deValid, 0);
    check("R6 em cleared", emValid, 0); check("R5 no retake under squash", squash, 0);
    settle();
    deClass = 3'd4; brTrue = 1'b0;
    @(negedge clk);
    check("R5 untaken branch", squash, 0);
  endtask

  task automatic testWriteback();
    settle();
    emClass = 3'd3; #1;
    check("R11 store writes memory", memWrite, 1);
    @(negedge clk);
    check("R11 store no writeback", mwValid, 0);
    emClass = 3'd5;
    @(negedge clk);
    check("R11 undefined as RI writes back", mwValid, 1);
    check("R11 no memory write", memWrite, 0);
    emClass = 3'd4;
    @(negedge clk);
    check("R11 branch no writeback", mwValid, 0);
    emClass = 3'd2;
    @(negedge clk);
    check("R11 load writes back", mwValid, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testLoadUse();
    testForward();
    testFlush();
    testBranch();
    testWriteback();
    finishRun();
  end

endmodule